// File: doc/BRIEF.md
# SPI Command Frame Decoder

This block is a 16-bit serial slave that configures a three-channel phase amplifier and gives software a path to read the chip's fault status. A host selects it by pulling chip select low, toggles a clock that rests high, and shifts a frame in most significant bit first. The six leading bits of the frame are a command code. The block returns a response frame on a data output that is enabled only while it is selected. The response repeats the command code one bit position lower and, for read commands, carries eight bits of status.

The serial lines are oversampled by the system clock through synchronizers, so all edge handling happens in one clock domain. Configuration changes only when chip select returns high, and only if the frame carried exactly sixteen clock pulses and a legal command code. Any other frame sets a sticky error flag. The fault-status storage sits outside the block. The block takes a snapshot of that storage through a capture pulse when a frame starts and asks for it to be cleared through a clear pulse after a valid read.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, sample/hold mode, calibration mode, the gain code, the error flag, the data output and its enable are all 0.
- R2: The data-output enable is low while chip select is high and goes high after chip select falls, before the first clock edge.
- R3: In every response, bit 15 and bit 8 are 0 and bits 14..9 repeat received bits 15..10. The data output is 0 whenever its enable is low.
- R4: Command 000001 in bits 15..10 loads bit 7 into sample/hold mode and bit 6 into calibration mode.
- R5: Command 000010 loads bits 7..6 into the gain code (00 = x1, 01 = x2, 10 = x3, 11 = x4) and leaves the mode bits alone.
- R6: Configuration outputs do not change during a frame. They change only after chip select rises.
- R7: A frame with 15 or 17 clock pulses sets the error flag and leaves all configuration unchanged.
- R8: Commands 000011 and 011000 are accepted and change nothing. Any code other than the six legal codes (000001, 000010, 000011, 001000, 010000, 011000) sets the error flag and changes nothing.
- R9: Command 001000 returns in bits 7..0 the status input as captured when chip select fell. When such a frame is valid, it produces one clear pulse; an invalid one produces none.
- R10: Command 010000 returns the error flag in bit 7 (bits 6..0 are 0), and a valid frame with this command clears the flag.
- R11: Each chip-select fall produces exactly one single-cycle capture pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock, idles high |
| cs_n_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in, MSB first |
| miso_o | output | 1 | Serial data out, MSB first |
| miso_oe_o | output | 1 | Enable for the serial data output driver |
| diag_snap_o | output | 1 | Capture pulse to the status storage at frame start |
| diag_stat_i | input | 8 | Status group presented by the external storage |
| diag_clr_o | output | 1 | Clear pulse to the status storage after a valid status read |
| sh_mode_o | output | 1 | Phase amplifier sample/hold mode enable |
| cal_mode_o | output | 1 | Phase amplifier calibration (short) mode enable |
| gain_o | output | 2 | Phase amplifier gain code |
| spi_err_o | output | 1 | Sticky serial-protocol error flag |

## Verification
The hardest case to reach from the pins is the boundary between a frame's start and a change in the status storage. The response must hold the value captured at the chip-select fall even if the storage changes a few cycles later. The bench changes the status input right after selecting the block and then checks that the read returns the earlier value. Frames one pulse short and one pulse long are built by a frame task that takes the pulse count as an argument. Each error is then read back through the error-read command, which checks the flag and its clearing on the same port.

// File: rtl/spi_cmd_pkg.sv
// Shared command codes and helpers for the SPI command frame decoder.
// Assumes a six-bit command field at the top of each frame.
package spi_cmd_pkg;

    localparam int CMD_BITS = 6;

    typedef enum logic [CMD_BITS-1:0] {
        CMD_AMP_MODE = 6'b000001,
        CMD_AMP_GAIN = 6'b000010,
        CMD_SPARE_A  = 6'b000011,
        CMD_DIAG_G1  = 6'b001000,
        CMD_DIAG_G2  = 6'b010000,
        CMD_SPARE_B  = 6'b011000
    } cmd_code_e;

    // True when the code is one of the accepted commands.
    function automatic logic cmd_is_legal(input logic [CMD_BITS-1:0] code);
        logic ok;
        case (code)
            CMD_AMP_MODE, CMD_AMP_GAIN, CMD_SPARE_A,
            CMD_DIAG_G1, CMD_DIAG_G2, CMD_SPARE_B: ok = 1'b1;
            default:                               ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchronizer for one asynchronous input.
// Assumes STAGES >= 2; the reset value matches the line's idle level.
module spi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
// Edge detector on an already synchronized signal.
// Pulses are one system clock wide and combinational from the current level.
module spi_edge_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev;

    // Remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev;
    assign fall_o = ~lvl_i & prev;
endmodule

// File: rtl/spi_frame_shifter.sv
// Serial framing: samples data on clock rises, counts rises, latches the
// command field once it is complete, and drives the response on clock falls.
// Assumes edge pulses come from one system clock domain.
module spi_frame_shifter #(
    parameter int FRAME_BITS = 16,
    parameter int DATA_BITS  = 8,
    parameter int CMD_BITS   = 6,
    parameter int CNT_W      = $clog2(FRAME_BITS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_low_i,
    input  logic                 cs_fall_i,
    input  logic                 cs_rise_i,
    input  logic                 sck_rise_i,
    input  logic                 sck_fall_i,
    input  logic                 mosi_i,
    input  logic [DATA_BITS-1:0] rsp_data_i,
    output logic [CMD_BITS-1:0]  code_o,
    output logic [1:0]           arg_o,
    output logic [CMD_BITS-1:0]  cmd_o,
    output logic [CNT_W-1:0]     rise_cnt_o,
    output logic                 miso_o,
    output logic                 oe_o
);
    localparam int          IDX_W     = $clog2(DATA_BITS);
    localparam int          DATA_FIRST = FRAME_BITS - DATA_BITS + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      rcnt;
    logic [CNT_W-1:0]      fcnt;
    logic [CMD_BITS-1:0]   cmd_q;
    logic                  nxt_bit;

    // Count sampling edges, saturating so over-long frames stay visible.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall_i)              rcnt <= '0;
        else if (sck_rise_i && cs_low_i && rcnt != CNT_MAX) rcnt <= rcnt + 1'b1;
    end

    // Shift received bits in on each sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     shreg <= '0;
        else if (sck_rise_i && cs_low_i) shreg <= {shreg[FRAME_BITS-2:0], mosi_i};
    end

    // Latch the command code as soon as its last bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall_i) cmd_q <= '0;
        else if (sck_rise_i && cs_low_i && rcnt == CNT_W'(CMD_BITS - 1))
            cmd_q <= {shreg[CMD_BITS-2:0], mosi_i};
    end

    // Count output edges within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall_i)              fcnt <= '0;
        else if (sck_fall_i && cs_low_i && fcnt != CNT_MAX) fcnt <= fcnt + 1'b1;
    end

    // Choose the response bit for the next output edge.
    always_comb begin
        int k;
        k = int'(fcnt) + 1;
        nxt_bit = 1'b0;
        if (k >= 2 && k <= CMD_BITS + 1)
            nxt_bit = shreg[0];
        else if (k >= DATA_FIRST && k <= FRAME_BITS)
            nxt_bit = rsp_data_i[IDX_W'(FRAME_BITS - k)];
    end

    // Drive the data output and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso_o <= 1'b0;
            oe_o   <= 1'b0;
        end else if (cs_fall_i) begin
            miso_o <= 1'b0;
            oe_o   <= 1'b1;
        end else if (cs_rise_i) begin
            miso_o <= 1'b0;
            oe_o   <= 1'b0;
        end else if (sck_fall_i && cs_low_i) begin
            miso_o <= nxt_bit;
        end
    end

    assign code_o     = shreg[FRAME_BITS-1 -: CMD_BITS];
    assign arg_o      = shreg[DATA_BITS-1 -: 2];
    assign cmd_o      = cmd_q;
    assign rise_cnt_o = rcnt;
endmodule

// File: rtl/spi_cmd_regs.sv
// Command execution: commits configuration at the end of a valid frame,
// keeps the sticky error flag, snapshots status at frame start and issues
// the clear pulse. Assumes frame fields are stable when chip select rises.
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int DATA_BITS  = 8,
    parameter int CNT_W      = $clog2(FRAME_BITS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_fall_i,
    input  logic                 cs_rise_i,
    input  logic [CMD_BITS-1:0]  code_i,
    input  logic [1:0]           arg_i,
    input  logic [CMD_BITS-1:0]  cmd_i,
    input  logic [CNT_W-1:0]     rise_cnt_i,
    input  logic [DATA_BITS-1:0] diag_stat_i,
    output logic [DATA_BITS-1:0] rsp_data_o,
    output logic                 diag_snap_o,
    output logic                 diag_clr_o,
    output logic                 sh_mode_o,
    output logic                 cal_mode_o,
    output logic [1:0]           gain_o,
    output logic                 spi_err_o
);
    logic [DATA_BITS-1:0] stat_snap;
    logic                 err_snap;
    logic                 frame_ok;

    assign frame_ok = (rise_cnt_i == CNT_W'(FRAME_BITS)) && cmd_is_legal(code_i);

    // Capture status and the error flag when a frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_snap   <= '0;
            err_snap    <= 1'b0;
            diag_snap_o <= 1'b0;
        end else begin
            diag_snap_o <= cs_fall_i;
            if (cs_fall_i) begin
                stat_snap <= diag_stat_i;
                err_snap  <= spi_err_o;
            end
        end
    end

    // Select response payload from the latched command.
    always_comb begin
        case (cmd_i)
            CMD_DIAG_G1: rsp_data_o = stat_snap;
            CMD_DIAG_G2: rsp_data_o = {err_snap, {(DATA_BITS-1){1'b0}}};
            default:     rsp_data_o = '0;
        endcase
    end

    // Commit configuration, error and clear at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mode_o  <= 1'b0;
            cal_mode_o <= 1'b0;
            gain_o     <= 2'b00;
            spi_err_o  <= 1'b0;
            diag_clr_o <= 1'b0;
        end else begin
            diag_clr_o <= 1'b0;
            if (cs_rise_i) begin
                if (!frame_ok) begin
                    spi_err_o <= 1'b1;
                end else begin
                    case (code_i)
                        CMD_AMP_MODE: begin
                            sh_mode_o  <= arg_i[1];
                            cal_mode_o <= arg_i[0];
                        end
                        CMD_AMP_GAIN: gain_o     <= arg_i;
                        CMD_DIAG_G1:  diag_clr_o <= 1'b1;
                        CMD_DIAG_G2:  spi_err_o  <= 1'b0;
                        default:      ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_decoder.sv
// Top level: synchronizes the serial lines, detects their edges, and joins
// the framing and command-execution stages. Assumes the system clock is at
// least eight times the serial clock.
module spi_cmd_decoder #(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 16,
    parameter int DATA_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck_i,
    input  logic                 cs_n_i,
    input  logic                 mosi_i,
    output logic                 miso_o,
    output logic                 miso_oe_o,
    output logic                 diag_snap_o,
    input  logic [DATA_BITS-1:0] diag_stat_i,
    output logic                 diag_clr_o,
    output logic                 sh_mode_o,
    output logic                 cal_mode_o,
    output logic [1:0]           gain_o,
    output logic                 spi_err_o
);
    import spi_cmd_pkg::*;

    localparam int CNT_W = $clog2(FRAME_BITS) + 1;

    logic sck_q, cs_q, mosi_q;
    logic sck_rise, sck_fall, cs_rise, cs_fall;
    logic [CMD_BITS-1:0]  code, cmd;
    logic [1:0]           arg;
    logic [CNT_W-1:0]     rise_cnt;
    logic [DATA_BITS-1:0] rsp_data;

    spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck
        (.clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_q));
    spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs
        (.clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_q));
    spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi
        (.clk(clk), .rst_n(rst_n), .d_i(mosi_i), .q_o(mosi_q));

    spi_edge_det #(.RST_VAL(1'b1)) u_edge_sck
        (.clk(clk), .rst_n(rst_n), .lvl_i(sck_q), .rise_o(sck_rise), .fall_o(sck_fall));
    spi_edge_det #(.RST_VAL(1'b1)) u_edge_cs
        (.clk(clk), .rst_n(rst_n), .lvl_i(cs_q), .rise_o(cs_rise), .fall_o(cs_fall));

    spi_frame_shifter #(
        .FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS),
        .CMD_BITS(CMD_BITS), .CNT_W(CNT_W)
    ) u_shifter (
        .clk(clk), .rst_n(rst_n),
        .cs_low_i(~cs_q), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
        .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .mosi_i(mosi_q),
        .rsp_data_i(rsp_data),
        .code_o(code), .arg_o(arg), .cmd_o(cmd), .rise_cnt_o(rise_cnt),
        .miso_o(miso_o), .oe_o(miso_oe_o)
    );

    spi_cmd_regs #(
        .FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
        .code_i(code), .arg_i(arg), .cmd_i(cmd), .rise_cnt_i(rise_cnt),
        .diag_stat_i(diag_stat_i), .rsp_data_o(rsp_data),
        .diag_snap_o(diag_snap_o), .diag_clr_o(diag_clr_o),
        .sh_mode_o(sh_mode_o), .cal_mode_o(cal_mode_o),
        .gain_o(gain_o), .spi_err_o(spi_err_o)
    );
endmodule

// File: rtl/spi_cmd_decoder_sva.sv
// Property checker for the SPI command frame decoder, attached by bind.
module spi_cmd_decoder_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_rise,
    input logic       miso_o,
    input logic       miso_oe_o,
    input logic       diag_snap_o,
    input logic       diag_clr_o,
    input logic       sh_mode_o,
    input logic       cal_mode_o,
    input logic [1:0] gain_o,
    input logic       spi_err_o
);
    // R3: an undriven line carries no data.
    a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe_o |-> !miso_o);

    // R2: the output enable turns on together with the frame-start capture.
    a_r2_oe_with_snap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe_o) |-> diag_snap_o);

    // R6: configuration moves only right after a chip-select rise.
    a_r6_cfg_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sh_mode_o, cal_mode_o, gain_o}) |-> $past(cs_rise));

    // R7: the error flag is raised only at frame end.
    a_r7_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_err_o) |-> $past(cs_rise));

    // R9: the clear request is a single-cycle pulse.
    a_r9_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        diag_clr_o |=> !diag_clr_o);

    // R11: the capture request is a single-cycle pulse.
    a_r11_snap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        diag_snap_o |=> !diag_snap_o);
endmodule

bind spi_cmd_decoder spi_cmd_decoder_sva u_sva (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .diag_snap_o(diag_snap_o), .diag_clr_o(diag_clr_o),
    .sh_mode_o(sh_mode_o), .cal_mode_o(cal_mode_o),
    .gain_o(gain_o), .spi_err_o(spi_err_o)
);

// File: tb/spi_cmd_decoder_tb_top.sv
// Directed bench for the SPI command frame decoder.
module spi_cmd_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic       miso, miso_oe, snap, clr, sh, cal, err;
    logic [1:0] gain;
    logic [7:0] diag_stat = 8'h00;

    int         n_chk = 0, n_bad = 0;
    int         snap_cnt = 0, clr_cnt = 0;
    logic [15:0] last_dout;
    logic       oe_idle, oe_act;
    logic [3:0] pre_cfg;
    logic [7:0] stat_late = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
        .miso_o(miso), .miso_oe_o(miso_oe), .diag_snap_o(snap),
        .diag_stat_i(diag_stat), .diag_clr_o(clr),
        .sh_mode_o(sh), .cal_mode_o(cal), .gain_o(gain), .spi_err_o(err)
    );

    always @(posedge clk) begin
        if (snap) snap_cnt <= snap_cnt + 1;
        if (clr)  clr_cnt  <= clr_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One frame with a chosen number of clock pulses.
    task automatic spi_frame(input logic [15:0] din, input int nclk);
        logic [15:0] dout;
        dout = '0;
        oe_idle = miso_oe;
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        oe_act = miso_oe;
        diag_stat = stat_late;
        for (int i = 0; i < nclk; i++) begin
            sck = 1'b0;
            mosi = (i < 16) ? din[15-i] : 1'b0;
            repeat (HP) @(negedge clk);
            if (i < 16) dout[15-i] = miso;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
        end
        pre_cfg = {sh, cal, gain};
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        last_dout = dout;
    endtask

    task automatic t_reset;
        chk("R1 sh", sh, 0); chk("R1 cal", cal, 0); chk("R1 gain", gain, 0);
        chk("R1 err", err, 0); chk("R1 oe", miso_oe, 0); chk("R1 miso", miso, 0);
    endtask

    task automatic t_mode;
        spi_frame(16'h0480, 16);
        chk("R2 oe idle", oe_idle, 0); chk("R2 oe active", oe_act, 1);
        chk("R3 echo mode", last_dout, 16'h0200);
        chk("R4 sh set", sh, 1); chk("R4 cal clear", cal, 0);
        chk("R2 oe after", miso_oe, 0);
        spi_frame(16'h0440, 16);
        chk("R4 sh clear", sh, 0); chk("R4 cal set", cal, 1);
    endtask

    task automatic t_gain;
        spi_frame(16'h08C0, 16);
        chk("R6 gain held before cs rise", pre_cfg[1:0], 2'b00);
        chk("R5 gain x4", gain, 2'b11);
        chk("R3 echo gain", last_dout, 16'h0400);
        chk("R5 modes kept", {sh, cal}, 2'b01);
        spi_frame(16'h0880, 16);
        chk("R5 gain x3", gain, 2'b10);
        chk("R6 gain held mid", pre_cfg[1:0], 2'b11);
    endtask

    task automatic t_count;
        spi_frame(16'h0840, 15);
        chk("R7 short gain kept", gain, 2'b10); chk("R7 short err", err, 1);
        spi_frame(16'h4000, 16);
        chk("R10 read err set", last_dout, 16'h2080); chk("R10 cleared", err, 0);
        spi_frame(16'h0840, 17);
        chk("R7 long gain kept", gain, 2'b10); chk("R7 long err", err, 1);
        spi_frame(16'h4000, 16);
        chk("R10 cleared again", err, 0);
        spi_frame(16'h4000, 16);
        chk("R10 read err clear", last_dout, 16'h2000);
    endtask

    task automatic t_cmds;
        spi_frame(16'h1CC0, 16);
        chk("R8 illegal err", err, 1);
        chk("R8 illegal cfg kept", {sh, cal, gain}, 4'b0110);
        spi_frame(16'h4000, 16);
        chk("R10 clear after illegal", err, 0);
        spi_frame(16'h80C0, 16);
        chk("R8 msb code err", err, 1);
        spi_frame(16'h4000, 16);
        spi_frame(16'h0CC0, 16);
        chk("R8 spare A no err", err, 0);
        chk("R8 spare A cfg kept", {sh, cal, gain}, 4'b0110);
        spi_frame(16'h60C0, 16);
        chk("R8 spare B no err", err, 0);
        chk("R8 spare B cfg kept", {sh, cal, gain}, 4'b0110);
        chk("R3 echo spare B", last_dout, 16'h3000);
    endtask

    task automatic t_diag;
        int c0, s0;
        diag_stat = 8'hA5; stat_late = 8'h3C;
        repeat (4) @(negedge clk);
        c0 = clr_cnt; s0 = snap_cnt;
        spi_frame(16'h2000, 16);
        chk("R9 read captured status", last_dout, 16'h10A5);
        chk("R9 one clear pulse", clr_cnt - c0, 1);
        chk("R11 one capture pulse", snap_cnt - s0, 1);
        c0 = clr_cnt;
        spi_frame(16'h2000, 15);
        chk("R9 no clear on bad frame", clr_cnt - c0, 0);
        chk("R7 bad read err", err, 1);
        spi_frame(16'h4000, 16);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset;
        t_mode;
        t_gain;
        t_count;
        t_cmds;
        t_diag;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule